// File: doc/BRIEF.md
# Two-Wire Serial Configuration Register Writer

This block is a slave on a two-wire serial bus (clock line and data line, open drain). It accepts write transactions from a bus host and stores the data bytes in an internal file of 256 byte-wide configuration registers. The whole file is presented to the rest of the chip as one flat parallel bus. Both bus lines are sampled against a faster system clock, so the block needs no clock of its own from the bus.

A host opens a transaction with a start condition. It then sends a device-address byte, and the block acknowledges only when that byte selects it for writing. Next comes a register-address byte, which sets an internal pointer. Every following byte is stored at the pointer, and the pointer then moves to the next register, so a burst fills consecutive registers. The pointer wraps at the end of the file. The seven-bit device address is a fixed five-bit prefix plus two bits taken from strap pins. This lets up to four of these blocks share one bus. Read transactions and clock stretching are not supported.

Top module: `i2c_cfg_writer`

## Requirements
- R1: After reset all 256 registers read as 0x00 on `regs_out` and `sda_oe` is low.
- R2: A start is a falling data line while the clock line is high. It begins address reception. A stop is a rising data line while the clock line is high. After a stop, bytes clocked without a new start get no acknowledge and change no register.
- R3: The first byte after a start is sent MSB first as 1,0,0,0,1,`strap[1]`,`strap[0]`, followed by the direction bit. Direction 0 means write. Changing the strap pins changes which address is accepted.
- R4: The block acknowledges the matching device-address byte, the register-address byte and every data byte. It does this by holding `sda_oe` high from the clock fall that ends bit 8 to the clock fall that ends bit 9. `sda_oe` changes 3 system clocks after the corresponding fall on `scl_in`.
- R5: Bits are sampled on the rising clock line. The register-address byte loads the pointer. Each data byte is written to the register the pointer selects, and the pointer then increases by one.
- R6: If the device address does not match, the block gives no acknowledge. It changes no register until the next start.
- R7: A matching address with direction bit 1 gets no acknowledge, and the rest of that transaction is ignored.
- R8: The pointer wraps from 255 to 0 within a burst.
- R9: A start in the middle of a transaction restarts address reception. Registers already written keep their values.
- R10: A written byte appears on `regs_out` 3 system clocks after the clock-line fall that ends its eighth bit. No register changes at any other time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| strap | input | 2 | Low two bits of the device address |
| sda_oe | output | 1 | Pull data line low (acknowledge) when high |
| regs_out | output | 2048 | Register file, register n at bits [8n+7:8n] |

## Verification
Both results of this block, the acknowledge enable and a register update, are due three system clocks after the clock-line fall that ends the eighth bit of a byte. The enable is withdrawn three clocks after the fall that ends the ninth bit. The bench records the cycle in which its reference model changes an expected value. Its per-clock comparison of `regs_out` and `sda_oe` then waits four clocks after that mark. The explicit acknowledge checks sample in the middle of the ninth clock-high phase, well after the window has settled.

// File: rtl/cfgw_pkg.sv
package cfgw_pkg;

    localparam int REG_AW   = 8;
    localparam int BYTE_W   = 8;
    localparam int NREGS    = 1 << REG_AW;
    localparam int BIT_CNT_W = 4;

    localparam logic [4:0] DEV_PREFIX = 5'b10001;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_DEV,
        PH_REG,
        PH_DATA,
        PH_SKIP
    } phase_t;

    typedef struct packed {
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    typedef struct packed {
        logic              en;
        logic [REG_AW-1:0] addr;
        logic [BYTE_W-1:0] data;
    } wr_req_t;

    function automatic logic dev_hit(input logic [BYTE_W-1:0] b, input logic [1:0] strap);
        return (b[7:1] == {DEV_PREFIX, strap}) && !b[0];
    endfunction

endpackage

// File: rtl/cfgw_sync.sv
module cfgw_sync
    import cfgw_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_in,
    input  logic    sda_in,
    output bus_ev_t ev
);
    logic [STAGES-1:0] scl_ff, sda_ff;
    logic              scl_d, sda_d;
    logic              scl_s, sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_in};
            sda_ff <= {sda_ff[STAGES-2:0], sda_in};
            scl_d  <= scl_ff[STAGES-1];
            sda_d  <= sda_ff[STAGES-1];
        end
    end

    assign scl_s = scl_ff[STAGES-1];
    assign sda_s = sda_ff[STAGES-1];

    always_comb begin
        ev.sda      = sda_s;
        ev.scl_rise = scl_s & ~scl_d;
        ev.scl_fall = ~scl_s & scl_d;
        ev.start    = scl_s & scl_d & sda_d & ~sda_s;
        ev.stop     = scl_s & scl_d & ~sda_d & sda_s;
    end

endmodule

// File: rtl/cfgw_proto.sv
module cfgw_proto
    import cfgw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic [1:0]        strap,
    output logic              sda_oe,
    output wr_req_t           wr,
    output phase_t            phase,
    output logic [REG_AW-1:0] ptr
);
    logic [BIT_CNT_W-1:0] cnt;
    logic [BYTE_W-1:0]    shreg;
    logic                 active;
    logic                 byte_end;
    logic                 ack_end;

    assign active   = (phase != PH_IDLE) && (phase != PH_SKIP);
    assign byte_end = active && ev.scl_fall && (cnt == BIT_CNT_W'(8));
    assign ack_end  = active && ev.scl_fall && (cnt == BIT_CNT_W'(9));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            cnt    <= '0;
            shreg  <= '0;
            ptr    <= '0;
            sda_oe <= 1'b0;
        end else if (ev.start) begin
            phase  <= PH_DEV;
            cnt    <= '0;
            sda_oe <= 1'b0;
        end else if (ev.stop) begin
            phase  <= PH_IDLE;
            cnt    <= '0;
            sda_oe <= 1'b0;
        end else if (active) begin
            if (ev.scl_rise && cnt < BIT_CNT_W'(9)) begin
                cnt <= cnt + 1'b1;
                if (cnt < BIT_CNT_W'(8))
                    shreg <= {shreg[BYTE_W-2:0], ev.sda};
            end
            if (byte_end) begin
                unique case (phase)
                    PH_DEV: begin
                        if (dev_hit(shreg, strap)) begin
                            phase  <= PH_REG;
                            sda_oe <= 1'b1;
                        end else begin
                            phase  <= PH_SKIP;
                        end
                    end
                    PH_REG: begin
                        ptr    <= shreg[REG_AW-1:0];
                        phase  <= PH_DATA;
                        sda_oe <= 1'b1;
                    end
                    PH_DATA: begin
                        ptr    <= ptr + 1'b1;
                        sda_oe <= 1'b1;
                    end
                    default: ;
                endcase
            end else if (ack_end) begin
                sda_oe <= 1'b0;
                cnt    <= '0;
            end
        end
    end

    always_comb begin
        wr.en   = byte_end && (phase == PH_DATA) && !ev.start && !ev.stop;
        wr.addr = ptr;
        wr.data = shreg;
    end

endmodule

// File: rtl/cfgw_regfile.sv
module cfgw_regfile
    import cfgw_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  wr_req_t                  wr,
    output logic [NREGS*BYTE_W-1:0]  regs_out
);
    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        logic [BYTE_W-1:0] r;
        always_ff @(posedge clk) begin
            if (rst)
                r <= '0;
            else if (wr.en && wr.addr == REG_AW'(g))
                r <= wr.data;
        end
        assign regs_out[g*BYTE_W +: BYTE_W] = r;
    end

endmodule

// File: rtl/i2c_cfg_writer.sv
module i2c_cfg_writer
    import cfgw_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    scl_in,
    input  logic                    sda_in,
    input  logic [1:0]              strap,
    output logic                    sda_oe,
    output logic [NREGS*BYTE_W-1:0] regs_out
);
    bus_ev_t           ev;
    wr_req_t           wr;
    phase_t            phase;
    logic [REG_AW-1:0] ptr;

    cfgw_sync #(.STAGES(2)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .ev     (ev)
    );

    cfgw_proto u_proto (
        .clk    (clk),
        .rst    (rst),
        .ev     (ev),
        .strap  (strap),
        .sda_oe (sda_oe),
        .wr     (wr),
        .phase  (phase),
        .ptr    (ptr)
    );

    cfgw_regfile u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr       (wr),
        .regs_out (regs_out)
    );

endmodule

// File: rtl/i2c_cfg_writer_chk.sv
module i2c_cfg_writer_chk
    import cfgw_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic                    sda_oe,
    input logic                    scl_fall,
    input logic                    start,
    input logic                    wr_en,
    input logic [REG_AW-1:0]       ptr,
    input phase_t                  phase,
    input logic [NREGS*BYTE_W-1:0] regs_out
);
    // R4: acknowledge enable only turns on right after a clock-line fall
    p_oe_on_fall_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> $past(scl_fall));

    // R9: a start always withdraws the acknowledge
    p_start_release_r9: assert property (@(posedge clk) disable iff (rst)
        start |=> !sda_oe);

    // R5 / R8: pointer advances by one (wrapping) after each write
    p_ptr_step_r5: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> ptr == $past(ptr) + 1'b1);

    // R10: registers move only on a write strobe
    p_regs_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(regs_out));

    // R6 / R7: an ignored transaction never acknowledges
    p_skip_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SKIP) |-> !sda_oe);

    // R2: idle bus never acknowledges
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE) |-> !sda_oe);

endmodule

bind i2c_cfg_writer i2c_cfg_writer_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .sda_oe   (sda_oe),
    .scl_fall (ev.scl_fall),
    .start    (ev.start),
    .wr_en    (wr.en),
    .ptr      (ptr),
    .phase    (phase),
    .regs_out (regs_out)
);

// File: tb/i2c_cfg_writer_tb_top.sv
module i2c_cfg_writer_tb_top;
    localparam int Q  = 5;
    localparam int NR = 256;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_drv = 1'b1;
    logic sda_drv = 1'b1;
    logic [1:0] strap = 2'b10;
    logic sda_oe;
    logic [NR*8-1:0] regs_out;
    logic sda_line;

    assign sda_line = sda_drv & ~sda_oe;

    always #5 clk = ~clk;

    i2c_cfg_writer dut_i (
        .clk      (clk),
        .rst      (rst),
        .scl_in   (scl_drv),
        .sda_in   (sda_line),
        .strap    (strap),
        .sda_oe   (sda_oe),
        .regs_out (regs_out)
    );

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int mark = 0;
    bit done = 0;
    bit cmp_on = 0;

    // behavioural reference model
    logic [7:0] exp_regs [NR];
    logic [7:0] exp_ptr = 8'd0;
    logic       exp_oe = 1'b0;
    int         mst = 0; // 0 idle, 1 device byte, 2 reg byte, 3 data, 4 ignore

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // per-clock comparison, held off until the 3-clock latency has elapsed
    always @(negedge clk) begin
        if (cmp_on && !rst && (cyc - mark) >= 4) begin
            chk(sda_oe == exp_oe, "R4", "sda_oe per clock", 32'(sda_oe), 32'(exp_oe));
            for (int i = 0; i < NR; i++)
                if (regs_out[i*8 +: 8] !== exp_regs[i])
                    chk(1'b0, "R10", $sformatf("reg %0d per clock", i),
                        32'(regs_out[i*8 +: 8]), 32'(exp_regs[i]));
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic bus_start();
        sda_drv = 1'b1; wait_clk(Q);
        scl_drv = 1'b1; wait_clk(Q);
        sda_drv = 1'b0; mst = 1; exp_oe = 1'b0; mark = cyc; wait_clk(2 * Q);
        scl_drv = 1'b0; wait_clk(Q);
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; wait_clk(Q);
        scl_drv = 1'b1; wait_clk(Q);
        sda_drv = 1'b1; mst = 0; exp_oe = 1'b0; mark = cyc; wait_clk(2 * Q);
    endtask

    task automatic send_byte(input logic [7:0] b, input string req);
        for (int i = 7; i >= 0; i--) begin
            sda_drv = b[i]; wait_clk(Q);
            scl_drv = 1'b1; wait_clk(2 * Q);
            scl_drv = 1'b0;
            if (i == 0) begin
                mark = cyc;
                case (mst)
                    1: if (b[7:1] == {5'b10001, strap} && !b[0]) begin
                           exp_oe = 1'b1; mst = 2;
                       end else mst = 4;
                    2: begin exp_ptr = b; exp_oe = 1'b1; mst = 3; end
                    3: begin exp_regs[exp_ptr] = b; exp_ptr = exp_ptr + 8'd1; exp_oe = 1'b1; end
                    default: ;
                endcase
            end
            wait_clk(Q);
        end
        sda_drv = 1'b1; wait_clk(Q);
        scl_drv = 1'b1; wait_clk(Q);
        chk(sda_oe == exp_oe, req, "acknowledge", 32'(sda_oe), 32'(exp_oe));
        chk(sda_line == ~exp_oe, req, "data line at ack", 32'(sda_line), 32'(~exp_oe));
        wait_clk(Q);
        scl_drv = 1'b0; exp_oe = 1'b0; mark = cyc; wait_clk(Q);
    endtask

    task automatic chk_reg(input int a, input logic [7:0] v, input string req);
        chk(regs_out[a*8 +: 8] == v, req, $sformatf("reg %0d", a),
            32'(regs_out[a*8 +: 8]), 32'(v));
    endtask

    initial begin
        for (int i = 0; i < NR; i++) exp_regs[i] = 8'h00;
        wait_clk(4);
        rst = 1'b0;
        wait_clk(2);
        // R1: reset state
        chk(sda_oe == 1'b0, "R1", "sda_oe after reset", 32'(sda_oe), 0);
        chk(regs_out == '0, "R1", "regs after reset", 32'(regs_out[31:0]), 0);
        cmp_on = 1;

        // R3 R5: burst of three bytes, strap = 10
        bus_start();
        send_byte(8'b1000110_0, "R3");
        send_byte(8'h10, "R5");
        send_byte(8'hA1, "R5");
        send_byte(8'hB2, "R5");
        send_byte(8'hC3, "R5");
        bus_stop();
        chk_reg(16, 8'hA1, "R5"); chk_reg(17, 8'hB2, "R5"); chk_reg(18, 8'hC3, "R5");

        // R6: wrong address, whole transaction ignored
        bus_start();
        send_byte(8'b1000111_0, "R6");
        send_byte(8'h10, "R6");
        send_byte(8'h55, "R6");
        bus_stop();
        chk_reg(16, 8'hA1, "R6");

        // R7: read direction refused
        bus_start();
        send_byte(8'b1000110_1, "R7");
        send_byte(8'h20, "R7");
        send_byte(8'h66, "R7");
        bus_stop();
        chk_reg(32, 8'h00, "R7");

        // R8: pointer wrap
        bus_start();
        send_byte(8'b1000110_0, "R8");
        send_byte(8'hFE, "R8");
        send_byte(8'h11, "R8");
        send_byte(8'h22, "R8");
        send_byte(8'h33, "R8");
        bus_stop();
        chk_reg(254, 8'h11, "R8"); chk_reg(255, 8'h22, "R8"); chk_reg(0, 8'h33, "R8");

        // R9: repeated start in mid-burst
        bus_start();
        send_byte(8'b1000110_0, "R9");
        send_byte(8'h40, "R9");
        send_byte(8'h77, "R9");
        bus_start();
        send_byte(8'b1000110_0, "R9");
        send_byte(8'h80, "R9");
        send_byte(8'h88, "R9");
        bus_stop();
        chk_reg(64, 8'h77, "R9"); chk_reg(65, 8'h00, "R9"); chk_reg(128, 8'h88, "R9");

        // R2: bytes after a stop without a new start are ignored
        send_byte(8'b1000110_0, "R2");
        send_byte(8'h90, "R2");
        send_byte(8'h99, "R2");
        chk_reg(144, 8'h00, "R2");

        // R3: new strap value moves the accepted address
        strap = 2'b01;
        bus_start();
        send_byte(8'b1000110_0, "R3");
        bus_stop();
        bus_start();
        send_byte(8'b1000101_0, "R3");
        send_byte(8'hA0, "R3");
        send_byte(8'h5A, "R3");
        bus_stop();
        chk_reg(160, 8'h5A, "R3");

        wait_clk(10);
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        wait_clk(150000);
        if (!done) begin
            done = 1;
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule